// File: doc/BRIEF.md
# Instruction Control Decoder

This block turns the operation fields of a 32-bit instruction word into the steering and write-enable signals that a single-cycle datapath needs. It has no clock and no state. It reads the opcode in bits 31:26 and, for register-form instructions, the function code in bits 5:0. It then produces, in the same cycle, the following signals:

- the register-file write enable,
- the destination-register choice,
- the immediate extension mode,
- the ALU second-operand source,
- the ALU operation,
- the memory write enable,
- the write-back source,
- the next-PC branch select.

Six instructions are recognised: register add and subtract, OR with an immediate, load word, store word and branch-if-equal. Any other opcode, and any other function code under the register-form opcode, produces a setting that changes no architectural state: neither write enable is raised and the PC advances sequentially. The steering outputs that an instruction leaves unused are driven to zero. Only the fields marked in the requirements are promised.

Top module: `ctrl_decoder`

## Requirements
- R1: Opcode 6'h00 with function code 6'h20 (add) gives reg_we=1, dst_is_rd=1, alu_use_imm=0, alu_op=2'b00 (ADD), mem_we=0, wb_from_mem=0, pc_branch_sel=0.
- R2: Opcode 6'h00 with function code 6'h22 (subtract) gives reg_we=1, dst_is_rd=1, alu_use_imm=0, alu_op=2'b01 (SUB), mem_we=0, wb_from_mem=0, pc_branch_sel=0.
- R3: Opcode 6'h0D (OR immediate) gives reg_we=1, dst_is_rd=0, imm_signed=0, alu_use_imm=1, alu_op=2'b10 (OR), mem_we=0, wb_from_mem=0, pc_branch_sel=0.
- R4: Opcode 6'h23 (load word) gives reg_we=1, dst_is_rd=0, imm_signed=1, alu_use_imm=1, alu_op=2'b00 (ADD), mem_we=0, wb_from_mem=1, pc_branch_sel=0.
- R5: Opcode 6'h2B (store word) gives reg_we=0, mem_we=1, imm_signed=1, alu_use_imm=1, alu_op=2'b00 (ADD), pc_branch_sel=0.
- R6: Opcode 6'h04 (branch if equal) gives reg_we=0, mem_we=0, alu_use_imm=0, alu_op=2'b01 (SUB), pc_branch_sel=1. pc_branch_sel is 1 for no other instruction word.
- R7: Opcode 6'h00 with any function code other than 6'h20 or 6'h22 gives reg_we=0, mem_we=0, pc_branch_sel=0.
- R8: Every opcode outside {6'h00, 6'h0D, 6'h23, 6'h2B, 6'h04} gives reg_we=0, mem_we=0, pc_branch_sel=0.
- R9: Bits 25:6 never change any output. Bits 5:0 change no output when the opcode is not 6'h00.
- R10: reg_we and mem_we are never 1 together for any instruction word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word; opcode in bits 31:26, function code in bits 5:0 |
| pc_branch_sel | output | 1 | 1 selects the branch target as next PC, 0 selects PC+4 |
| reg_we | output | 1 | Register-file write enable |
| dst_is_rd | output | 1 | 1 writes the rd field register, 0 the rt field register |
| imm_signed | output | 1 | 1 sign-extends the 16-bit immediate, 0 zero-extends it |
| alu_use_imm | output | 1 | 1 feeds the extended immediate to the ALU second operand |
| alu_op | output | 2 | ALU operation: 00 ADD, 01 SUB, 10 OR |
| mem_we | output | 1 | Data-memory write enable |
| wb_from_mem | output | 1 | 1 writes memory read data back, 0 the ALU result |

## Verification
The hardest case to reach is the register-form opcode carrying a function code that is not recognised. At that point the write enable is gated by the low six bits alone, while every other opcode must ignore those same bits. The stimulus covers both sides of this. It walks every function code under opcode 6'h00. It also places the add and subtract function codes in the low bits of immediate-form and unknown opcodes. The register and immediate fields are filled with varied patterns as well, to show that they leak into nothing.

// File: rtl/ctrl_dec_pkg.sv
package ctrl_dec_pkg;

  localparam int unsigned OPC_W = 6;
  localparam int unsigned FNC_W = 6;

  typedef logic [OPC_W-1:0] opcode_t;
  typedef logic [FNC_W-1:0] funct_t;

  localparam opcode_t OPC_REG   = 6'h00;
  localparam opcode_t OPC_ORI   = 6'h0D;
  localparam opcode_t OPC_LOAD  = 6'h23;
  localparam opcode_t OPC_STORE = 6'h2B;
  localparam opcode_t OPC_BEQ   = 6'h04;

  localparam funct_t FNC_ADD = 6'h20;
  localparam funct_t FNC_SUB = 6'h22;

  typedef enum logic [1:0] {
    ALU_ADD  = 2'b00,
    ALU_SUB  = 2'b01,
    ALU_OR   = 2'b10,
    ALU_NONE = 2'b11
  } alu_op_e;

  typedef enum logic [2:0] {
    CLS_REG,
    CLS_ORI,
    CLS_LOAD,
    CLS_STORE,
    CLS_BEQ,
    CLS_BAD
  } iclass_e;

  typedef struct packed {
    logic    br_sel;
    logic    reg_we;
    logic    dst_rd;
    logic    imm_sx;
    logic    use_imm;
    alu_op_e alu;
    logic    mem_we;
    logic    wb_mem;
  } ctrl_t;

  localparam ctrl_t CTRL_SAFE = '{br_sel: 1'b0, reg_we: 1'b0, dst_rd: 1'b0,
                                  imm_sx: 1'b0, use_imm: 1'b0, alu: ALU_ADD,
                                  mem_we: 1'b0, wb_mem: 1'b0};

endpackage

// File: rtl/dec_fields.sv
module dec_fields #(
  parameter int unsigned INSTR_W = 32,
  parameter int unsigned OP_W    = 6,
  parameter int unsigned FN_W    = 6
) (
  input  logic [INSTR_W-1:0] instr,
  output logic [OP_W-1:0]    opcode,
  output logic [FN_W-1:0]    funct
);
  localparam int unsigned OP_LSB = INSTR_W - OP_W;

  assign opcode = instr[INSTR_W-1:OP_LSB];
  assign funct  = instr[FN_W-1:0];
endmodule

// File: rtl/dec_class.sv
module dec_class
  import ctrl_dec_pkg::*;
(
  input  opcode_t opcode,
  output iclass_e iclass
);
  always_comb begin
    case (opcode)
      OPC_REG:   iclass = CLS_REG;
      OPC_ORI:   iclass = CLS_ORI;
      OPC_LOAD:  iclass = CLS_LOAD;
      OPC_STORE: iclass = CLS_STORE;
      OPC_BEQ:   iclass = CLS_BEQ;
      default:   iclass = CLS_BAD;
    endcase
  end
endmodule

// File: rtl/dec_funct.sv
module dec_funct
  import ctrl_dec_pkg::*;
(
  input  funct_t  funct,
  output logic    known,
  output alu_op_e alu
);
  always_comb begin
    known = 1'b0;
    alu   = ALU_ADD;
    case (funct)
      FNC_ADD: begin known = 1'b1; alu = ALU_ADD; end
      FNC_SUB: begin known = 1'b1; alu = ALU_SUB; end
      default: begin known = 1'b0; alu = ALU_ADD; end
    endcase
  end
endmodule

// File: rtl/dec_table.sv
module dec_table
  import ctrl_dec_pkg::*;
(
  input  iclass_e iclass,
  input  logic    reg_fn_ok,
  input  alu_op_e reg_fn_alu,
  output ctrl_t   ctrl
);
  always_comb begin
    ctrl = CTRL_SAFE;
    case (iclass)
      CLS_REG: begin
        if (reg_fn_ok) begin
          ctrl.reg_we = 1'b1;
          ctrl.dst_rd = 1'b1;
          ctrl.alu    = reg_fn_alu;
        end
      end
      CLS_ORI: begin
        ctrl.reg_we  = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.imm_sx  = 1'b0;
        ctrl.alu     = ALU_OR;
      end
      CLS_LOAD: begin
        ctrl.reg_we  = 1'b1;
        ctrl.imm_sx  = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.alu     = ALU_ADD;
        ctrl.wb_mem  = 1'b1;
      end
      CLS_STORE: begin
        ctrl.mem_we  = 1'b1;
        ctrl.imm_sx  = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.alu     = ALU_ADD;
      end
      CLS_BEQ: begin
        ctrl.br_sel = 1'b1;
        ctrl.alu    = ALU_SUB;
      end
      default: ctrl = CTRL_SAFE;
    endcase
  end
endmodule

// File: rtl/ctrl_decoder.sv
module ctrl_decoder
  import ctrl_dec_pkg::*;
#(
  parameter int unsigned INSTR_W = 32
) (
  input  logic [INSTR_W-1:0] instr,
  output logic               pc_branch_sel,
  output logic               reg_we,
  output logic               dst_is_rd,
  output logic               imm_signed,
  output logic               alu_use_imm,
  output logic [1:0]         alu_op,
  output logic               mem_we,
  output logic               wb_from_mem
);
  opcode_t opcode;
  funct_t  funct;
  iclass_e iclass;
  logic    fn_known;
  alu_op_e fn_alu;
  ctrl_t   ctrl;

  dec_fields #(.INSTR_W(INSTR_W), .OP_W(OPC_W), .FN_W(FNC_W)) u_fields (
    .instr  (instr),
    .opcode (opcode),
    .funct  (funct)
  );

  dec_class u_class (
    .opcode (opcode),
    .iclass (iclass)
  );

  dec_funct u_funct (
    .funct (funct),
    .known (fn_known),
    .alu   (fn_alu)
  );

  dec_table u_table (
    .iclass     (iclass),
    .reg_fn_ok  (fn_known),
    .reg_fn_alu (fn_alu),
    .ctrl       (ctrl)
  );

  assign pc_branch_sel = ctrl.br_sel;
  assign reg_we        = ctrl.reg_we;
  assign dst_is_rd     = ctrl.dst_rd;
  assign imm_signed    = ctrl.imm_sx;
  assign alu_use_imm   = ctrl.use_imm;
  assign alu_op        = ctrl.alu;
  assign mem_we        = ctrl.mem_we;
  assign wb_from_mem   = ctrl.wb_mem;
endmodule

// File: rtl/ctrl_decoder_chk.sv
module ctrl_decoder_chk #(
  parameter int unsigned INSTR_W = 32
) (
  input logic [INSTR_W-1:0] instr,
  input logic               pc_branch_sel,
  input logic               reg_we,
  input logic               dst_is_rd,
  input logic               mem_we,
  input logic               wb_from_mem
);
  logic [5:0] op_f;
  logic [5:0] fn_f;
  logic       op_known;

  assign op_f     = instr[INSTR_W-1:INSTR_W-6];
  assign fn_f     = instr[5:0];
  assign op_known = (op_f == 6'h00) || (op_f == 6'h0D) || (op_f == 6'h23) ||
                    (op_f == 6'h2B) || (op_f == 6'h04);

  always_comb begin
    // R10
    we_excl_chk: assert (!(reg_we && mem_we));
    // R6
    br_only_beq_chk: assert (pc_branch_sel == (op_f == 6'h04));
    // R8
    bad_op_safe_chk: assert (op_known || (!reg_we && !mem_we && !pc_branch_sel));
    // R7
    bad_fn_safe_chk: assert (op_f != 6'h00 || fn_f == 6'h20 || fn_f == 6'h22 ||
                             (!reg_we && !mem_we && !pc_branch_sel));
    // R4
    wb_mem_load_chk: assert (!(reg_we && wb_from_mem) || op_f == 6'h23);
    // R1
    rd_dest_reg_chk: assert (!(reg_we && dst_is_rd) || op_f == 6'h00);
  end
endmodule

bind ctrl_decoder ctrl_decoder_chk #(.INSTR_W(INSTR_W)) u_chk (
  .instr         (instr),
  .pc_branch_sel (pc_branch_sel),
  .reg_we        (reg_we),
  .dst_is_rd     (dst_is_rd),
  .mem_we        (mem_we),
  .wb_from_mem   (wb_from_mem)
);

// File: tb/tb_ctrl_decoder.sv
module tb_ctrl_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic        clk;
  logic        rst_n;
  logic [31:0] instr;
  logic        pc_branch_sel, reg_we, dst_is_rd, imm_signed, alu_use_imm;
  logic [1:0]  alu_op;
  logic        mem_we, wb_from_mem;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  ctrl_decoder dut (
    .instr         (instr),
    .pc_branch_sel (pc_branch_sel),
    .reg_we        (reg_we),
    .dst_is_rd     (dst_is_rd),
    .imm_signed    (imm_signed),
    .alu_use_imm   (alu_use_imm),
    .alu_op        (alu_op),
    .mem_we        (mem_we),
    .wb_from_mem   (wb_from_mem)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] rform(logic [4:0] rs, logic [4:0] rt,
                                        logic [4:0] rd, logic [4:0] sh,
                                        logic [5:0] fn);
    return {6'h00, rs, rt, rd, sh, fn};
  endfunction

  function automatic logic [31:0] iform(logic [5:0] op, logic [4:0] rs,
                                        logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d instr=%h", req, what, act, exp, instr);
    end
  endtask

  task automatic drive(logic [31:0] w);
    @(negedge clk);
    instr = w;
    #1;
  endtask

  // Snapshot of every output, used to compare words that differ only in ignored bits.
  function automatic logic [8:0] outs();
    return {pc_branch_sel, reg_we, dst_is_rd, imm_signed, alu_use_imm,
            alu_op, mem_we, wb_from_mem};
  endfunction

  task automatic t_reset();
    drive(32'h0000_0000);
    chk("R7", "reset reg_we", reg_we, 0);
    chk("R7", "reset mem_we", mem_we, 0);
    chk("R7", "reset br", pc_branch_sel, 0);
  endtask

  task automatic t_add();
    logic [31:0] pats[3] = '{rform(5'd1, 5'd2, 5'd3, 5'd0, 6'h20),
                             rform(5'd31, 5'd17, 5'd9, 5'd7, 6'h20),
                             rform(5'd0, 5'd0, 5'd0, 5'd31, 6'h20)};
    foreach (pats[i]) begin
      drive(pats[i]);
      chk("R1", "add reg_we", reg_we, 1);
      chk("R1", "add dst_is_rd", dst_is_rd, 1);
      chk("R1", "add use_imm", alu_use_imm, 0);
      chk("R1", "add alu_op", alu_op, 0);
      chk("R1", "add mem_we", mem_we, 0);
      chk("R1", "add wb", wb_from_mem, 0);
      chk("R1", "add br", pc_branch_sel, 0);
    end
  endtask

  task automatic t_sub();
    drive(rform(5'd4, 5'd5, 5'd6, 5'd0, 6'h22));
    chk("R2", "sub reg_we", reg_we, 1);
    chk("R2", "sub dst_is_rd", dst_is_rd, 1);
    chk("R2", "sub use_imm", alu_use_imm, 0);
    chk("R2", "sub alu_op", alu_op, 1);
    chk("R2", "sub mem_we", mem_we, 0);
    chk("R2", "sub wb", wb_from_mem, 0);
    chk("R2", "sub br", pc_branch_sel, 0);
  endtask

  task automatic t_ori();
    drive(iform(6'h0D, 5'd3, 5'd8, 16'h8020));
    chk("R3", "ori reg_we", reg_we, 1);
    chk("R3", "ori dst_is_rd", dst_is_rd, 0);
    chk("R3", "ori imm_signed", imm_signed, 0);
    chk("R3", "ori use_imm", alu_use_imm, 1);
    chk("R3", "ori alu_op", alu_op, 2);
    chk("R3", "ori mem_we", mem_we, 0);
    chk("R3", "ori wb", wb_from_mem, 0);
    chk("R3", "ori br", pc_branch_sel, 0);
  endtask

  task automatic t_load();
    drive(iform(6'h23, 5'd29, 5'd10, 16'hFFFC));
    chk("R4", "lw reg_we", reg_we, 1);
    chk("R4", "lw dst_is_rd", dst_is_rd, 0);
    chk("R4", "lw imm_signed", imm_signed, 1);
    chk("R4", "lw use_imm", alu_use_imm, 1);
    chk("R4", "lw alu_op", alu_op, 0);
    chk("R4", "lw mem_we", mem_we, 0);
    chk("R4", "lw wb", wb_from_mem, 1);
    chk("R4", "lw br", pc_branch_sel, 0);
  endtask

  task automatic t_store();
    drive(iform(6'h2B, 5'd29, 5'd11, 16'h0008));
    chk("R5", "sw reg_we", reg_we, 0);
    chk("R5", "sw mem_we", mem_we, 1);
    chk("R5", "sw imm_signed", imm_signed, 1);
    chk("R5", "sw use_imm", alu_use_imm, 1);
    chk("R5", "sw alu_op", alu_op, 0);
    chk("R5", "sw br", pc_branch_sel, 0);
  endtask

  task automatic t_beq();
    drive(iform(6'h04, 5'd1, 5'd2, 16'hFFFF));
    chk("R6", "beq reg_we", reg_we, 0);
    chk("R6", "beq mem_we", mem_we, 0);
    chk("R6", "beq use_imm", alu_use_imm, 0);
    chk("R6", "beq alu_op", alu_op, 1);
    chk("R6", "beq br", pc_branch_sel, 1);
  endtask

  task automatic t_bad_funct();
    for (int f = 0; f < 64; f++) begin
      if (f == 'h20 || f == 'h22) continue;
      drive(rform(5'd7, 5'd8, 5'd9, 5'd1, 6'(f)));
      chk("R7", "badfn reg_we", reg_we, 0);
      chk("R7", "badfn mem_we", mem_we, 0);
      chk("R7", "badfn br", pc_branch_sel, 0);
    end
  endtask

  task automatic t_sweep_op();
    for (int op = 0; op < 64; op++) begin
      bit known = (op == 'h00 || op == 'h0D || op == 'h23 || op == 'h2B || op == 'h04);
      for (int fsel = 0; fsel < 2; fsel++) begin
        drive({6'(op), 20'hA5A5A, (fsel == 0) ? 6'h20 : 6'h22});
        // R10 write enables exclusive on every word
        chk("R10", "we exclusive", int'(reg_we && mem_we), 0);
        chk("R6", "br only on beq", pc_branch_sel, int'(op == 'h04));
        if (!known) begin
          chk("R8", "badop reg_we", reg_we, 0);
          chk("R8", "badop mem_we", mem_we, 0);
        end
      end
    end
  endtask

  task automatic t_ignored();
    logic [8:0] ref_o;
    logic [5:0] ops[4] = '{6'h0D, 6'h23, 6'h2B, 6'h04};
    foreach (ops[i]) begin
      drive({ops[i], 20'h00000, 6'h00});
      ref_o = outs();
      drive({ops[i], 20'hFFFFF, 6'h20});
      chk("R9", "low fields ignored a", int'(outs()), int'(ref_o));
      drive({ops[i], 20'h5A5A5, 6'h3F});
      chk("R9", "low fields ignored b", int'(outs()), int'(ref_o));
    end
    drive(rform(5'd0, 5'd0, 5'd0, 5'd0, 6'h22));
    ref_o = outs();
    drive(rform(5'd31, 5'd31, 5'd31, 5'd31, 6'h22));
    chk("R9", "reg fields ignored", int'(outs()), int'(ref_o));
  endtask

  initial begin
    instr = 32'h0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_add();
    t_sub();
    t_ori();
    t_load();
    t_store();
    t_beq();
    t_bad_funct();
    t_sweep_op();
    t_ignored();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule